// File: doc/BRIEF.md
# Frequency Offset Tracking Loop

This block follows the carrier frequency error seen by a receive datapath. On each symbol strobe it takes a signed error sample from the demodulator and scales it by an arithmetic right shift. It adds the scaled value into a 16-bit signed estimate and clamps the result to a tracking window. The window is set as a fraction of a signed bandwidth scale input. Two loop gains are configured on their own: one applies while the receiver is still looking for the sync word, the other once sync has been found.

Updates happen only in the frequency-shift style modulation modes. An optional freeze holds the estimate until carrier sense rises, so the loop does not drift on noise during long idle receive periods. Software reads the upper byte of the estimate as a status value. A commit strobe adds the full estimate into a separate synthesizer-offset register, which saturates. A clear input zeroes the estimate on entry to receive.

Top module: `freq_offset_tracker`

## Requirements
- R1: After a synchronous reset the estimate, the status byte and the synthesizer offset all read zero.
- R2: When a symbol strobe is taken in a tracking mode with sync not yet found, the estimate grows by the error sample arithmetically shifted right by 3 + the pre-sync gain code. The gain code is 2 bits wide, so the shift runs from 3 to 6.
- R3: When sync is found, the post-sync gain code picks the shift in the same way, and the pre-sync code has no effect.
- R4: Mode codes 0, 1 and 3 track. Code 2 and codes 4 to 7 leave the estimate unchanged.
- R5: When the freeze enable is high and carrier sense is low, a symbol strobe leaves the estimate unchanged. When carrier sense is high, updates proceed as usual.
- R6: After an update the estimate lies within ±|scale|·32, ±|scale|·64 or ±|scale|·128 for limit codes 0, 1 and 2. Any sum beyond that range is clamped to the nearest bound.
- R7: Limit code 3 disables tracking, and the estimate holds its value.
- R8: The status output always equals bits 15:8 of the estimate.
- R9: A commit strobe adds the estimate, as it stood before that clock edge, into the synthesizer offset. The sum saturates to the signed 16-bit range. Without a commit the synthesizer offset is unchanged.
- R10: A clear sets the estimate to zero and takes priority over a simultaneous update.
- R11: Without a symbol strobe the estimate is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Zero the estimate (receive entry) |
| sym_valid_i | input | 1 | One error sample is present this cycle |
| err_i | input | 16 | Signed frequency error sample |
| mode_i | input | 3 | Modulation code: 0, 1 and 3 track |
| cs_i | input | 1 | Carrier sense |
| sync_i | input | 1 | Sync word found |
| freeze_en_i | input | 1 | Hold the estimate while carrier sense is low |
| gain_pre_i | input | 2 | Shift code before sync (shift = 3 + code) |
| gain_post_i | input | 2 | Shift code after sync (shift = 3 + code) |
| lim_sel_i | input | 2 | Window: 0 = BW/8, 1 = BW/4, 2 = BW/2, 3 = off |
| bw_scale_i | input | 8 | Signed bandwidth scale, taken as a magnitude |
| commit_i | input | 1 | Add the estimate into the synthesizer offset |
| est_o | output | 16 | Signed offset estimate |
| stat_o | output | 8 | Status byte: upper half of the estimate |
| synth_ofs_o | output | 16 | Signed synthesizer offset |

## Verification
The estimate, the status byte and the synthesizer offset are each one register deep. A strobe, clear or commit taken at one rising edge therefore shows at the outputs right after that edge. The bench changes inputs on the falling edge and reads the outputs on the following falling edge, which is one full rising edge later. It runs the commit and update cases in the same cycle, so it can show that a commit takes the estimate as it stood before the update.

// File: rtl/fot_pkg.sv
package fot_pkg;

    typedef enum logic [1:0] {
        LIM_EIGHTH  = 2'd0,
        LIM_QUARTER = 2'd1,
        LIM_HALF    = 2'd2,
        LIM_OFF     = 2'd3
    } lim_sel_e;

    typedef struct packed {
        logic [1:0] gain_pre;
        logic [1:0] gain_post;
        lim_sel_e   lim;
        logic       freeze_en;
    } loop_cfg_t;

    localparam int GAIN_SHIFT_BASE = 3;

    // frequency-shift style modes that the loop follows
    function automatic logic is_tracking_mode(input logic [2:0] m);
        return (m == 3'd0) || (m == 3'd1) || (m == 3'd3);
    endfunction

endpackage

// File: rtl/fot_gain.sv
module fot_gain #(
    parameter int ERR_W = 16,
    parameter int SUM_W = 18
) (
    input  logic                    sync_i,
    input  logic [1:0]              gain_pre_i,
    input  logic [1:0]              gain_post_i,
    input  logic signed [ERR_W-1:0] err_i,
    output logic signed [SUM_W-1:0] step_o
);
    localparam int SH_W = 4;

    logic [1:0]              code;
    logic [SH_W-1:0]         shamt;
    logic signed [SUM_W-1:0] err_x;

    always_comb begin
        code   = sync_i ? gain_post_i : gain_pre_i;
        shamt  = SH_W'(fot_pkg::GAIN_SHIFT_BASE) + SH_W'(code);
        err_x  = {{(SUM_W-ERR_W){err_i[ERR_W-1]}}, err_i};
        step_o = err_x >>> shamt;
    end

endmodule

// File: rtl/fot_limit.sv
module fot_limit #(
    parameter int BW_W  = 8,
    parameter int EST_W = 16,
    parameter int SUM_W = 18
) (
    input  fot_pkg::lim_sel_e       lim_sel_i,
    input  logic signed [BW_W-1:0]  bw_scale_i,
    output logic signed [SUM_W-1:0] lim_mag_o,
    output logic                    track_en_o
);
    // BW/8 of a full-scale estimate: scale sits in the top BW_W bits
    localparam int SCALE_SH  = EST_W - BW_W - 3;
    localparam int EST_MAX_I = (1 << (EST_W-1)) - 1;
    localparam logic signed [SUM_W-1:0] EST_MAX = $signed(SUM_W'(EST_MAX_I));

    logic signed [BW_W:0]    bw_x;
    logic signed [BW_W:0]    mag;
    logic [4:0]              shamt;
    logic signed [SUM_W-1:0] wide;

    always_comb begin
        bw_x  = {bw_scale_i[BW_W-1], bw_scale_i};
        mag   = (bw_x < 0) ? -bw_x : bw_x;
        shamt = 5'(SCALE_SH) + 5'(lim_sel_i);
        wide  = $signed({{(SUM_W-BW_W-1){1'b0}}, mag}) <<< shamt;
        lim_mag_o  = (wide > EST_MAX) ? EST_MAX : wide;
        track_en_o = (lim_sel_i != fot_pkg::LIM_OFF);
    end

endmodule

// File: rtl/fot_acc.sv
module fot_acc #(
    parameter int EST_W = 16,
    parameter int SUM_W = 18
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr_i,
    input  logic                    upd_i,
    input  logic signed [SUM_W-1:0] step_i,
    input  logic signed [SUM_W-1:0] lim_mag_i,
    output logic signed [EST_W-1:0] est_o
);
    logic signed [SUM_W-1:0] est_x;
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] lim_neg;
    logic signed [SUM_W-1:0] nxt;

    always_comb begin
        est_x   = {{(SUM_W-EST_W){est_o[EST_W-1]}}, est_o};
        sum     = est_x + step_i;
        lim_neg = -lim_mag_i;
        if (sum > lim_mag_i)
            nxt = lim_mag_i;
        else if (sum < lim_neg)
            nxt = lim_neg;
        else
            nxt = sum;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            est_o <= '0;
        else if (upd_i)
            est_o <= nxt[EST_W-1:0];
    end

endmodule

// File: rtl/fot_synth.sv
module fot_synth #(
    parameter int EST_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    commit_i,
    input  logic signed [EST_W-1:0] est_i,
    output logic signed [EST_W-1:0] synth_o
);
    localparam logic signed [EST_W:0] MAX_V = {2'b00, {(EST_W-1){1'b1}}};
    localparam logic signed [EST_W:0] MIN_V = {2'b11, {(EST_W-1){1'b0}}};

    logic signed [EST_W:0] sum;
    logic signed [EST_W:0] sat;

    always_comb begin
        sum = {est_i[EST_W-1], est_i} + {synth_o[EST_W-1], synth_o};
        if (sum > MAX_V)
            sat = MAX_V;
        else if (sum < MIN_V)
            sat = MIN_V;
        else
            sat = sum;
    end

    always_ff @(posedge clk) begin
        if (rst)
            synth_o <= '0;
        else if (commit_i)
            synth_o <= sat[EST_W-1:0];
    end

endmodule

// File: rtl/freq_offset_tracker.sv
module freq_offset_tracker #(
    parameter int ERR_W  = 16,
    parameter int EST_W  = 16,
    parameter int BW_W   = 8,
    parameter int STAT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr_i,
    input  logic                     sym_valid_i,
    input  logic signed [ERR_W-1:0]  err_i,
    input  logic [2:0]               mode_i,
    input  logic                     cs_i,
    input  logic                     sync_i,
    input  logic                     freeze_en_i,
    input  logic [1:0]               gain_pre_i,
    input  logic [1:0]               gain_post_i,
    input  logic [1:0]               lim_sel_i,
    input  logic signed [BW_W-1:0]   bw_scale_i,
    input  logic                     commit_i,
    output logic signed [EST_W-1:0]  est_o,
    output logic [STAT_W-1:0]        stat_o,
    output logic signed [EST_W-1:0]  synth_ofs_o
);
    import fot_pkg::*;

    localparam int SUM_W = ((ERR_W > EST_W) ? ERR_W : EST_W) + 2;

    loop_cfg_t               cfg;
    logic signed [SUM_W-1:0] step;
    logic signed [SUM_W-1:0] lim_mag;
    logic                    track_en;
    logic                    upd;

    assign cfg = '{gain_pre:  gain_pre_i,
                   gain_post: gain_post_i,
                   lim:       lim_sel_e'(lim_sel_i),
                   freeze_en: freeze_en_i};

    fot_gain #(.ERR_W(ERR_W), .SUM_W(SUM_W)) i_gain (
        .sync_i      (sync_i),
        .gain_pre_i  (cfg.gain_pre),
        .gain_post_i (cfg.gain_post),
        .err_i       (err_i),
        .step_o      (step)
    );

    fot_limit #(.BW_W(BW_W), .EST_W(EST_W), .SUM_W(SUM_W)) i_limit (
        .lim_sel_i   (cfg.lim),
        .bw_scale_i  (bw_scale_i),
        .lim_mag_o   (lim_mag),
        .track_en_o  (track_en)
    );

    assign upd = sym_valid_i && is_tracking_mode(mode_i) && track_en
                 && !(cfg.freeze_en && !cs_i);

    fot_acc #(.EST_W(EST_W), .SUM_W(SUM_W)) i_acc (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (clr_i),
        .upd_i     (upd),
        .step_i    (step),
        .lim_mag_i (lim_mag),
        .est_o     (est_o)
    );

    fot_synth #(.EST_W(EST_W)) i_synth (
        .clk      (clk),
        .rst      (rst),
        .commit_i (commit_i),
        .est_i    (est_o),
        .synth_o  (synth_ofs_o)
    );

    assign stat_o = est_o[EST_W-1 -: STAT_W];

endmodule

// File: rtl/fot_checker.sv
module fot_checker #(
    parameter int EST_W = 16,
    parameter int SUM_W = 18
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    clr_i,
    input logic                    sym_valid_i,
    input logic [2:0]              mode_i,
    input logic                    cs_i,
    input logic                    freeze_en_i,
    input logic [1:0]              lim_sel_i,
    input logic                    commit_i,
    input logic signed [EST_W-1:0] est_o,
    input logic signed [EST_W-1:0] synth_ofs_o,
    input logic signed [SUM_W-1:0] lim_mag
);
    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (est_o == 0 && synth_ofs_o == 0)); // R1

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !fot_pkg::is_tracking_mode(mode_i)) |=> $stable(est_o)); // R4

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && freeze_en_i && !cs_i) |=> $stable(est_o)); // R5

    AST_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && sym_valid_i && lim_sel_i != 2'd3
         && fot_pkg::is_tracking_mode(mode_i) && !(freeze_en_i && !cs_i))
        |=> ($signed({{(SUM_W-EST_W){est_o[EST_W-1]}}, est_o}) <= $past(lim_mag)
             && $signed({{(SUM_W-EST_W){est_o[EST_W-1]}}, est_o}) >= -$past(lim_mag))); // R6

    AST_LIM_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && lim_sel_i == 2'd3) |=> $stable(est_o)); // R7

    AST_COMMIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit_i |=> $stable(synth_ofs_o)); // R9

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (est_o == 0)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !sym_valid_i) |=> $stable(est_o)); // R11

endmodule

bind freq_offset_tracker fot_checker #(.EST_W(EST_W), .SUM_W(SUM_W)) i_fot_checker (
    .clk         (clk),
    .rst         (rst),
    .clr_i       (clr_i),
    .sym_valid_i (sym_valid_i),
    .mode_i      (mode_i),
    .cs_i        (cs_i),
    .freeze_en_i (freeze_en_i),
    .lim_sel_i   (lim_sel_i),
    .commit_i    (commit_i),
    .est_o       (est_o),
    .synth_ofs_o (synth_ofs_o),
    .lim_mag     (lim_mag)
);

// File: tb/test_freq_offset_tracker.sv
module test_freq_offset_tracker;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               clr_i = 1'b0;
    logic               sym_valid_i = 1'b0;
    logic signed [15:0] err_i = '0;
    logic [2:0]         mode_i = '0;
    logic               cs_i = 1'b0;
    logic               sync_i = 1'b0;
    logic               freeze_en_i = 1'b0;
    logic [1:0]         gain_pre_i = '0;
    logic [1:0]         gain_post_i = '0;
    logic [1:0]         lim_sel_i = 2'd2;
    logic signed [7:0]  bw_scale_i = 8'sd64;
    logic               commit_i = 1'b0;
    logic signed [15:0] est_o;
    logic [7:0]         stat_o;
    logic signed [15:0] synth_ofs_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    freq_offset_tracker i_freq_offset_tracker (
        .clk(clk), .rst(rst), .clr_i(clr_i), .sym_valid_i(sym_valid_i),
        .err_i(err_i), .mode_i(mode_i), .cs_i(cs_i), .sync_i(sync_i),
        .freeze_en_i(freeze_en_i), .gain_pre_i(gain_pre_i),
        .gain_post_i(gain_post_i), .lim_sel_i(lim_sel_i),
        .bw_scale_i(bw_scale_i), .commit_i(commit_i), .est_o(est_o),
        .stat_o(stat_o), .synth_ofs_o(synth_ofs_o)
    );

    typedef struct packed {
        logic [2:0]         mode;
        logic               cs;
        logic               sync;
        logic               frz;
        logic [1:0]         gpre;
        logic [1:0]         gpost;
        logic [1:0]         lim;
        logic signed [7:0]  bw;
        logic signed [15:0] err;
        logic signed [15:0] exp;
        logic [7:0]         req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd2,  8'sd64,   16'sd800,    16'sd100, 8'd2}, // R2
        '{3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd2,  8'sd64,  -16'sd400,     16'sd50, 8'd2}, // R2
        '{3'd1, 1'b0, 1'b1, 1'b0, 2'd0, 2'd1, 2'd2,  8'sd64,  16'sd1600,    16'sd150, 8'd3}, // R3
        '{3'd1, 1'b0, 1'b1, 1'b0, 2'd0, 2'd3, 2'd2,  8'sd64,  16'sd6400,    16'sd250, 8'd3}, // R3
        '{3'd2, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd2,  8'sd64,  16'sd8000,    16'sd250, 8'd4}, // R4
        '{3'd3, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 2'd2,  8'sd64, -16'sd3200,    16'sd150, 8'd2}, // R2
        '{3'd0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 2'd2,  8'sd64,   16'sd800,    16'sd150, 8'd5}, // R5
        '{3'd0, 1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 2'd2,  8'sd64,   16'sd800,    16'sd250, 8'd5}, // R5
        '{3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd3,  8'sd64,   16'sd800,    16'sd250, 8'd7}, // R7
        '{3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0,  8'sd64, 16'sd30000,   16'sd2048, 8'd6}, // R6
        '{3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0,  8'sd64, -16'sd32768, -16'sd2048, 8'd6}, // R6
        '{3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0,  8'sd64,    -16'sd8, -16'sd2048, 8'd6}, // R6
        '{3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1,  8'sd64,     16'sd8, -16'sd2047, 8'd6}, // R6
        '{3'd0, 1'b1, 1'b0, 1'b0, 2'd3, 2'd0, 2'd1,  8'sd64,    -16'sd1, -16'sd2048, 8'd2}, // R2
        '{3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, -8'sd64,  -16'sd800, -16'sd2048, 8'd6}, // R6
        '{3'd0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd2, 8'sd127, 16'sd32767,   16'sd2047, 8'd6}, // R6
        '{3'd5, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd2, 8'sd127, 16'sd32767,   16'sd2047, 8'd4}  // R4
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive one symbol on the falling edge, result read one rising edge later
    task automatic sym(input logic signed [15:0] e, input logic com);
        err_i = e;
        sym_valid_i = 1'b1;
        commit_i = com;
        @(negedge clk);
        sym_valid_i = 1'b0;
        commit_i = 1'b0;
    endtask

    task automatic commit_only();
        commit_i = 1'b1;
        @(negedge clk);
        commit_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 est", int'(est_o), 0);
        check("R1 stat", int'(stat_o), 0);
        check("R1 synth", int'(synth_ofs_o), 0);

        for (int i = 0; i < NV; i++) begin
            mode_i      = VECS[i].mode;
            cs_i        = VECS[i].cs;
            sync_i      = VECS[i].sync;
            freeze_en_i = VECS[i].frz;
            gain_pre_i  = VECS[i].gpre;
            gain_post_i = VECS[i].gpost;
            lim_sel_i   = VECS[i].lim;
            bw_scale_i  = VECS[i].bw;
            sym(VECS[i].err, 1'b0);
            check($sformatf("R%0d vec %0d", VECS[i].req, i), int'(est_o), int'(VECS[i].exp));
            // R8: status byte tracks upper half
            check($sformatf("R8 vec %0d", i), int'(stat_o), int'(VECS[i].exp[15:8]));
        end

        // R9: commits accumulate the estimate (2047)
        mode_i = 3'd0; freeze_en_i = 1'b0;
        commit_only();
        check("R9 first commit", int'(synth_ofs_o), 2047);
        commit_only();
        check("R9 second commit", int'(synth_ofs_o), 4094);

        // R6: top of the widest window, |scale|=127 -> 16256
        bw_scale_i = 8'sd127; lim_sel_i = 2'd2; gain_pre_i = 2'd0;
        for (int k = 0; k < 4; k++) sym(16'sd32767, 1'b0);
        check("R6 window top", int'(est_o), 16256);
        check("R8 window top", int'(stat_o), 8'h3F);

        // R9: commit together with an update uses the pre-update estimate
        sym(-16'sd32768, 1'b1);
        check("R9 pre-update est", int'(synth_ofs_o), 20350);
        check("R2 step -4096", int'(est_o), 12160);
        commit_only();
        check("R9 commit 3", int'(synth_ofs_o), 32510);
        commit_only();
        check("R9 saturation", int'(synth_ofs_o), 32767);

        // R11 and R9: idle cycle changes nothing
        err_i = 16'sd8000;
        @(negedge clk);
        check("R11 idle est", int'(est_o), 12160);
        check("R9 no commit", int'(synth_ofs_o), 32767);

        // R10: clear wins over a simultaneous update
        clr_i = 1'b1;
        sym(16'sd8000, 1'b0);
        clr_i = 1'b0;
        check("R10 clear", int'(est_o), 0);
        check("R10 stat", int'(stat_o), 0);

        // R1: reset later in the run
        sym(16'sd800, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 late est", int'(est_o), 0);
        check("R1 late synth", int'(synth_ofs_o), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule